// File: doc/BRIEF.md
# Nine-bit multiprocessor UART receiver

This block is the receive half of an asynchronous serial port in the classic 8-bit controller style. It watches a serial line, finds start bits and samples each bit sixteen times. A majority vote over the three samples at the middle of the bit gives the bit value. A mode input picks one of three frame layouts. Mode 1 carries eight data bits. Modes 2 and 3 carry nine data bits. Mode 0 is the synchronous mode, which this receiver does not handle, so the receiver stays idle in mode 0. Every frame ends with a single stop bit.

A completed frame is presented on a valid/ready output. `rx_valid_o` is the receive-complete flag, and the host clears it by asserting `rx_ready_i`. The data and the extra bit stay stable for as long as valid is high. The receiver applies back-pressure by dropping frames. A frame that completes while valid is still high is discarded and does not touch the held data.

A multiprocessor control input can suppress frames. In the 9-bit modes it admits only address frames, which have their ninth bit set, so that slaves on a shared line are interrupted only by addresses. Host software compares the address and then clears the control bit to take the data frames that follow. In mode 1 the same input instead requires a valid stop bit. Two interrupt requests come out of the block. The receive request is the flag gated by its enable. The transmit request is an outside transmit-complete flag gated by its own enable.

Top module: `uart_mp_rx`

## Requirements
- R1: After reset, `rx_valid_o`, `rx_data_o`, `rx_bit9_o`, `rx_irq_o` and `tx_irq_o` are all 0.
- R2: In mode 1 (`mode_i` = 1) a frame is a low start bit, 8 data bits with the LSB first, and a stop bit. On acceptance, `rx_data_o` holds the data bits and `rx_bit9_o` holds the sampled stop bit.
- R3: In modes 2 and 3 (`mode_i` = 2 or 3) a frame is a start bit, 8 data bits with the LSB first, a ninth bit and a stop bit. On acceptance, `rx_bit9_o` holds the ninth bit.
- R4: In modes 2 and 3 with `sm2_i` = 1, a frame whose ninth bit is 0 is rejected and `rx_valid_o`, `rx_data_o` and `rx_bit9_o` keep their values. A frame whose ninth bit is 1 is accepted. With `sm2_i` = 0, both kinds are accepted.
- R5: In mode 1 with `sm2_i` = 1, a frame with a sampled stop bit of 0 is rejected and the outputs are unchanged. With `sm2_i` = 0, the same frame is accepted with `rx_bit9_o` = 0.
- R6: Each bit value is the majority of the samples taken at the 7th, 8th and 9th `tick_i` pulses of the bit, counting from 0. A single wrong sample among those three does not change the received value.
- R7: If the start bit does not vote low at mid-bit, the receiver returns to idle and reports no frame. A later complete frame is still received correctly.
- R8: While `rx_valid_o` is high, a newly completed frame is dropped and the held outputs stay stable. `rx_valid_o` goes low on the clock edge where `rx_valid_o` and `rx_ready_i` are both high.
- R9: With `rx_en_i` = 0 or `mode_i` = 0 the receiver ignores the line. No frame is reported and the held outputs stay unchanged.
- R10: `rx_irq_o` is high exactly when `rx_valid_o` and `rx_irq_en_i` are both high. `tx_irq_o` is high exactly when `tx_flag_i` and `tx_irq_en_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idle high, synchronised inside the block |
| tick_i | input | 1 | Sample strobe, 16 pulses per bit time |
| mode_i | input | 2 | Frame mode: 0 off (synchronous mode, not handled), 1 eight data bits, 2 and 3 nine data bits |
| sm2_i | input | 1 | Multiprocessor control bit |
| rx_en_i | input | 1 | Receive enable |
| rx_valid_o | output | 1 | Receive-complete flag, valid side of the output stream |
| rx_ready_i | input | 1 | Host clear, ready side of the output stream |
| rx_data_o | output | 8 | Received data byte |
| rx_bit9_o | output | 1 | Ninth bit in modes 2 and 3, stop bit in mode 1 |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_flag_i | input | 1 | Transmit-complete flag from the transmitter |
| tx_irq_en_i | input | 1 | Transmit interrupt enable |
| tx_irq_o | output | 1 | Transmit interrupt request |

## Verification
The rejection properties assume that `sm2_i` and `mode_i` are stable from the start bit until the cycle after a frame completes. The filtering decision is made against the current control bit, so a change during a frame would not be judged against the frame's own setting. The bench changes mode, control bit and enable only while the line is idle between frames. The stream properties assume nothing about `rx_ready_i`, so the bench holds it off across whole frames and pulses it for single cycles. The interrupt properties put no constraint on `tx_flag_i`.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC = 2'd0,
    MODE_8BIT = 2'd1,
    MODE_9BIT = 2'd2,
    MODE_9ALT = 2'd3
  } rx_mode_e;

  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_RUN  = 1'b1
  } fr_state_e;
endpackage

// File: rtl/uart_mp_sync.sv
module uart_mp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= d_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/uart_mp_framer.sv
module uart_mp_framer
  import uart_mp_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          nine_i,
  input  logic          tick_i,
  input  logic          rx_i,
  output logic          done_o,
  output logic          nine_o,
  output logic [DW-1:0] data_o,
  output logic          b9_o,
  output logic          stop_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DW + 3);
  localparam logic [CNT_W-1:0] S_A   = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] S_B   = CNT_W'(OSR/2);
  localparam logic [CNT_W-1:0] S_C   = CNT_W'(OSR/2 + 1);
  localparam logic [CNT_W-1:0] S_END = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] LAST8 = IDX_W'(DW + 1);
  localparam logic [IDX_W-1:0] LAST9 = IDX_W'(DW + 2);

  fr_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bidx;
  logic [IDX_W-1:0] last;
  logic             va, vb, maj;
  logic [DW:0]      shreg;
  logic             nine_q, stop_q, done_q;

  assign maj  = (va & vb) | (va & rx_i) | (vb & rx_i);
  assign last = nine_q ? LAST9 : LAST8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= FR_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      va     <= 1'b1;
      vb     <= 1'b1;
      shreg  <= '0;
      nine_q <= 1'b0;
      stop_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_i) begin
        st <= FR_IDLE;
      end else if (tick_i) begin
        case (st)
          FR_IDLE: begin
            if (!rx_i) begin
              st     <= FR_RUN;
              cnt    <= CNT_W'(1);
              bidx   <= '0;
              nine_q <= nine_i;
            end
          end
          FR_RUN: begin
            cnt <= (cnt == S_END) ? '0 : cnt + 1'b1;
            if (cnt == S_END) bidx <= bidx + 1'b1;
            if (cnt == S_A) va <= rx_i;
            if (cnt == S_B) vb <= rx_i;
            if (cnt == S_C) begin
              if (bidx == '0) begin
                if (maj) st <= FR_IDLE;
              end else if (bidx == last) begin
                st     <= FR_IDLE;
                stop_q <= maj;
                done_q <= 1'b1;
              end else begin
                shreg <= {maj, shreg[DW:1]};
              end
            end
          end
          default: st <= FR_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    if (nine_q) begin
      data_o = shreg[DW-1:0];
      b9_o   = shreg[DW];
    end else begin
      data_o = shreg[DW:1];
      b9_o   = stop_q;
    end
  end

  assign done_o = done_q;
  assign nine_o = nine_q;
  assign stop_o = stop_q;
endmodule

// File: rtl/uart_mp_gate.sv
module uart_mp_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic          nine_i,
  input  logic [DW-1:0] data_i,
  input  logic          b9_i,
  input  logic          stop_i,
  input  logic          sm2_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          b9_o
);
  logic pass, accept;

  assign pass   = !sm2_i || (nine_i ? b9_i : stop_i);
  assign accept = done_i && pass && !valid_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      b9_o    <= 1'b0;
    end else begin
      if (accept) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
        b9_o    <= b9_i;
      end else if (valid_o && ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_mp_irq.sv
module uart_mp_irq #(
  parameter int SOURCES = 2
) (
  input  logic [SOURCES-1:0] flag_i,
  input  logic [SOURCES-1:0] en_i,
  output logic [SOURCES-1:0] req_o
);
  generate
    for (genvar g = 0; g < SOURCES; g++) begin : g_src
      assign req_o[g] = flag_i[g] & en_i[g];
    end
  endgenerate
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd_i,
  input  logic          tick_i,
  input  logic [1:0]    mode_i,
  input  logic          sm2_i,
  input  logic          rx_en_i,
  output logic          rx_valid_o,
  input  logic          rx_ready_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_bit9_o,
  input  logic          rx_irq_en_i,
  output logic          rx_irq_o,
  input  logic          tx_flag_i,
  input  logic          tx_irq_en_i,
  output logic          tx_irq_o
);
  rx_mode_e      mode;
  logic          rx_s, active;
  logic          fr_done, fr_nine, fr_b9, fr_stop;
  logic [DW-1:0] fr_data;
  logic [1:0]    irq_req;

  assign mode   = rx_mode_e'(mode_i);
  assign active = rx_en_i && (mode != MODE_SYNC);

  uart_mp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rxd_i), .q_o(rx_s)
  );

  uart_mp_framer #(.DW(DW), .OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .active_i(active),
    .nine_i(mode == MODE_9BIT || mode == MODE_9ALT),
    .tick_i(tick_i), .rx_i(rx_s), .done_o(fr_done), .nine_o(fr_nine),
    .data_o(fr_data), .b9_o(fr_b9), .stop_o(fr_stop)
  );

  uart_mp_gate #(.DW(DW)) u_gate (
    .clk(clk), .rst_n(rst_n), .done_i(fr_done), .nine_i(fr_nine),
    .data_i(fr_data), .b9_i(fr_b9), .stop_i(fr_stop), .sm2_i(sm2_i),
    .ready_i(rx_ready_i), .valid_o(rx_valid_o), .data_o(rx_data_o),
    .b9_o(rx_bit9_o)
  );

  uart_mp_irq #(.SOURCES(2)) u_irq (
    .flag_i({tx_flag_i, rx_valid_o}),
    .en_i({tx_irq_en_i, rx_irq_en_i}),
    .req_o(irq_req)
  );

  assign rx_irq_o = irq_req[0];
  assign tx_irq_o = irq_req[1];
endmodule

// File: rtl/uart_mp_rx_chk.sv
module uart_mp_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en_i,
  input logic          sm2_i,
  input logic          rx_ready_i,
  input logic          rx_valid_o,
  input logic [DW-1:0] rx_data_o,
  input logic          rx_bit9_o,
  input logic          rx_irq_o,
  input logic          tx_irq_o,
  input logic          tx_flag_i,
  input logic          fr_done,
  input logic          fr_nine,
  input logic          fr_b9,
  input logic          fr_stop
);
  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && rx_ready_i |=> !rx_valid_o); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o) && $stable(rx_bit9_o)); // R8
  AST_DATA_FRAME_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done && fr_nine && sm2_i && !fr_b9 && !rx_valid_o |=> !rx_valid_o); // R4
  AST_BAD_STOP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done && !fr_nine && sm2_i && !fr_stop && !rx_valid_o |=> !rx_valid_o); // R5
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> !fr_done); // R9
  AST_RX_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o |-> rx_valid_o); // R10
  AST_TX_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_o |-> tx_flag_i); // R10
endmodule

bind uart_mp_rx uart_mp_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .sm2_i(sm2_i),
  .rx_ready_i(rx_ready_i), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
  .rx_bit9_o(rx_bit9_o), .rx_irq_o(rx_irq_o), .tx_irq_o(tx_irq_o),
  .tx_flag_i(tx_flag_i), .fr_done(fr_done), .fr_nine(fr_nine),
  .fr_b9(fr_b9), .fr_stop(fr_stop)
);

// File: tb/sim_uart_mp_rx.sv
`timescale 1ns/1ps
module sim_uart_mp_rx;
  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd_i = 1'b1;
  logic       tick_i = 1'b0;
  logic [1:0] mode_i = 2'd1;
  logic       sm2_i = 1'b0;
  logic       rx_en_i = 1'b1;
  logic       rx_ready_i = 1'b0;
  logic       rx_irq_en_i = 1'b1;
  logic       tx_flag_i = 1'b0;
  logic       tx_irq_en_i = 1'b0;
  logic       rx_valid_o, rx_bit9_o, rx_irq_o, tx_irq_o;
  logic [7:0] rx_data_o;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  ended = 1'b0;
  logic [7:0] exp_d = '0;
  logic       exp_b = 1'b0;

  always #4 clk = ~clk;

  uart_mp_rx u0 (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i), .tick_i(tick_i), .mode_i(mode_i),
    .sm2_i(sm2_i), .rx_en_i(rx_en_i), .rx_valid_o(rx_valid_o),
    .rx_ready_i(rx_ready_i), .rx_data_o(rx_data_o), .rx_bit9_o(rx_bit9_o),
    .rx_irq_en_i(rx_irq_en_i), .rx_irq_o(rx_irq_o), .tx_flag_i(tx_flag_i),
    .tx_irq_en_i(tx_irq_en_i), .tx_irq_o(tx_irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic one_tick(input logic v);
    rxd_i = v;
    repeat (DIV-1) @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic send_bit(input logic v, input int gpos);
    for (int t = 0; t < 16; t++) one_tick((t == gpos) ? ~v : v);
  endtask

  task automatic idle(input int n);
    for (int t = 0; t < n; t++) one_tick(1'b1);
  endtask

  task automatic send_frame(input logic nine, input logic [8:0] d,
                            input logic stop, input bit glitch);
    send_bit(1'b0, -1);
    for (int i = 0; i < (nine ? 9 : 8); i++)
      send_bit(d[i], glitch ? 7 + (i % 3) : -1);
    for (int t = 0; t < 10; t++) one_tick(stop);
    idle(10);
  endtask

  task automatic pop();
    @(negedge clk) rx_ready_i = 1'b1;
    @(negedge clk) rx_ready_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", rx_valid_o, 0);
    check("R1 data", rx_data_o, 0);
    check("R1 bit9", rx_bit9_o, 0);
    check("R1 rx_irq", rx_irq_o, 0);
    check("R1 tx_irq", tx_irq_o, 0);
    idle(4);

    // sweep: modes 1..3, sm2, ninth bit, stop bit, data patterns (R2 R3 R4 R5)
    for (int m = 1; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int n9 = 0; n9 < 2; n9++)
          for (int st = 0; st < 2; st++)
            for (int k = 0; k < 3; k++) begin
              logic [7:0] d;
              logic nine, acc;
              d    = 8'(8'h35 * (k + 1) + m * 17 + n9 * 64 + st);
              nine = (m >= 2);
              mode_i = 2'(m);
              sm2_i  = 1'(s);
              idle(2);
              send_frame(nine, {1'(n9), d}, 1'(st), 1'b0);
              acc = (s == 0) || (nine ? (n9 == 1) : (st == 1));
              if (acc) begin
                exp_d = d;
                exp_b = nine ? 1'(n9) : 1'(st);
              end
              check(nine ? "R3/R4 valid" : "R2/R5 valid", rx_valid_o, int'(acc));
              check(nine ? "R3/R4 data" : "R2/R5 data", rx_data_o, exp_d);
              check(nine ? "R3/R4 bit9" : "R2/R5 bit9", rx_bit9_o, exp_b);
              check("R10 rx_irq follows flag", rx_irq_o, int'(acc));
              if (acc) pop();
              check("R8 cleared by ready", rx_valid_o, 0);
            end

    // R6 single wrong sample at 7, 8 or 9 per bit
    mode_i = 2'd2; sm2_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [8:0] d9;
      d9 = 9'(9'h0A5 + k * 9'h06B);
      send_frame(1'b1, d9, 1'b1, 1'b1);
      check("R6 glitch data", rx_data_o, d9[7:0]);
      check("R6 glitch bit9", rx_bit9_o, d9[8]);
      exp_d = d9[7:0]; exp_b = d9[8];
      pop();
    end

    // R7 false start: low for 5 ticks only
    mode_i = 2'd1;
    for (int t = 0; t < 5; t++) one_tick(1'b0);
    idle(200);
    check("R7 no frame from false start", rx_valid_o, 0);
    check("R7 data held", rx_data_o, exp_d);
    send_frame(1'b0, 9'h0C3, 1'b1, 1'b0);
    check("R7 later frame valid", rx_valid_o, 1);
    check("R7 later frame data", rx_data_o, 8'hC3);
    exp_d = 8'hC3; exp_b = 1'b1;

    // R8 back-pressure: second frame dropped while flag set
    send_frame(1'b0, 9'h05A, 1'b0, 1'b0);
    check("R8 valid held", rx_valid_o, 1);
    check("R8 data held", rx_data_o, 8'hC3);
    check("R8 bit9 held", rx_bit9_o, 1);
    pop();
    check("R8 cleared", rx_valid_o, 0);

    // R9 disabled and mode 0
    rx_en_i = 1'b0;
    send_frame(1'b0, 9'h011, 1'b1, 1'b0);
    check("R9 disabled no frame", rx_valid_o, 0);
    check("R9 disabled data held", rx_data_o, exp_d);
    rx_en_i = 1'b1; mode_i = 2'd0;
    send_frame(1'b0, 9'h022, 1'b1, 1'b0);
    check("R9 mode0 no frame", rx_valid_o, 0);
    check("R9 mode0 data held", rx_data_o, exp_d);

    // R10 enables
    mode_i = 2'd3;
    send_frame(1'b1, 9'h133, 1'b1, 1'b0);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      rx_irq_en_i = c[0]; tx_flag_i = c[1]; tx_irq_en_i = c[2];
      #1;
      check("R10 rx_irq", rx_irq_o, int'(c[0]));
      check("R10 tx_irq", tx_irq_o, int'(c[1] & c[2]));
    end
    finish_run();
  end
endmodule